// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device side of a small serial flash memory. A host selects it with an active-low chip select and shifts command, address and data bytes in on a serial clock, most significant bit first. Input is sampled on the rising clock edge and output changes on the falling edge, as in SPI mode 0. The block decodes five operations: streaming read, byte program, sector erase, status read and an abort command. It keeps a 17-bit byte address. It drives serial output with a separate enable, so a pad can tri-state the line. It hands completed program and erase operations to a storage array through a simple synchronous port.

All pins are oversampled by a fast system clock. A write command does not touch the array when chip select rises. It starts a self-timed busy interval of a parameterized number of system cycles. The array request is issued only when that interval ends. For this reason an abort during the interval leaves the memory unchanged. Two inputs block writes: a write-protect input and a reset input, both active low. The busy state can be read through an active-low ready bit in the status byte.

Top module: `sflash_front`

## Requirements
- R1: Opcode 0xFF followed by three address bytes and two dummy bytes starts a read. Data bytes then stream out MSB first, with each bit changing after a falling SCK edge. The byte address increases by one after each byte.
- R2: Only the low 17 address bits are kept and bits 23..17 are ignored. A read that passes address 0x1FFFF continues at address 0.
- R3: Opcode 0x10, three address bytes, a data byte and one dummy byte, followed by chip select rising, start a program. After PROG_CYC system cycles, a one-cycle `mem_prog` pulse is issued, carrying that address on `mem_addr` and that byte on `mem_wdata`.
- R4: Opcode 0x20, address byte 23..16, address byte 15..8, one ignored byte, the confirm byte 0xD0 and one dummy byte, followed by chip select rising, start an erase. After ERASE_CYC system cycles, a one-cycle `mem_erase` pulse is issued, with `mem_addr` set to the sector base (low 8 bits zero).
- R5: Opcode 0x9F returns a status byte that repeats while chip select stays low. Bit 0 is 1 when the block is ready and 0 while a program or erase interval runs. Bits 7..1 read as 0.
- R6: `so_en` is low while chip select is high and during every opcode, address and dummy byte. It is high only in the data phase of a read or a status read.
- R7: A data byte of 0xFF in a program command, or a confirm byte of 0xFF in an erase command, cancels the command. No busy interval starts and no array request is issued.
- R8: While busy, an opcode byte of 0xFF ends the busy interval at once, and no array request is issued for the cancelled operation.
- R9: If `wp_n` or `hw_rst_n` is low when chip select rises after a complete write command, nothing starts.
- R10: While busy, every opcode except 0x9F and 0xFF is ignored. An erase whose confirm byte is not 0xD0 is ignored.
- R11: If chip select rises before the dummy byte of a program or erase command, the command is discarded.
- R12: `mem_prog` and `mem_erase` are never high together, and each request lasts exactly one system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write protect, active low |
| hw_rst_n | input | 1 | Write-inhibit reset pin, active low |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for the serial data out pad |
| mem_addr | output | ADDR_W | Array address for reads and write requests |
| mem_wdata | output | 8 | Program data |
| mem_prog | output | 1 | One-cycle byte program request |
| mem_erase | output | 1 | One-cycle sector erase request |
| mem_rdata | input | 8 | Array read data for `mem_addr` |

## Verification
The bench builds the block with PROG_CYC = 1500 and ERASE_CYC = 3000 system cycles. These values are long enough for a full status read, an abort command or a second ignored write command to fit inside a busy interval, which makes the busy-time behaviour observable. They are also short enough that many program and erase commits fit in one run. The default 17-bit address is kept, so the read wrap from 0x1FFFF to 0 and the discarding of the upper address bits are exercised on the real boundary.

// File: rtl/sflash_front.sv
module sflash_front #(
  parameter int ADDR_W    = 17,
  parameter int PROG_CYC  = 3500,
  parameter int ERASE_CYC = 400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              wp_n,
  input  logic              hw_rst_n,
  output logic              so,
  output logic              so_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_prog,
  output logic              mem_erase,
  input  logic [7:0]        mem_rdata
);
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {M_IGN, M_RD, M_PG, M_ER, M_ST} mode_t;

  logic sck_d1, sck_d2, si_d1, cs_d1, cs_d2;
  logic [2:0] bcnt, cyc, ocnt;
  logic [7:0] sh, osh, wdata;
  logic [ADDR_W-9:0] a_hi;
  logic [ADDR_W-1:0] addr;
  mode_t mode;
  logic armed, dphase, busy, pend_er, so_r;
  logic [CNT_W-1:0] cnt;

  wire rise = sck_d1 & ~sck_d2;
  wire fall = ~sck_d1 & sck_d2;
  wire cs_up = cs_d1 & ~cs_d2;
  wire [7:0] shn = {sh[6:0], si_d1};
  wire [ADDR_W-1:0] addr_full = {a_hi, shn};
  wire [7:0] nb = (mode == M_RD) ? mem_rdata : {7'b0, ~busy};
  wire is_wr = (mode == M_PG) || (mode == M_ER);

  assign so        = so_r;
  assign so_en     = dphase;
  assign mem_addr  = addr;
  assign mem_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d1 <= 1'b0; sck_d2 <= 1'b0; si_d1 <= 1'b0;
      cs_d1 <= 1'b1; cs_d2 <= 1'b1;
      bcnt <= '0; cyc <= '0; ocnt <= '0;
      sh <= '0; osh <= '0; wdata <= '0; a_hi <= '0; addr <= '0;
      mode <= M_IGN; armed <= 1'b0; dphase <= 1'b0;
      busy <= 1'b0; pend_er <= 1'b0; cnt <= '0; so_r <= 1'b0;
      mem_prog <= 1'b0; mem_erase <= 1'b0;
    end else begin
      sck_d1 <= sck; sck_d2 <= sck_d1; si_d1 <= si;
      cs_d1 <= cs_n; cs_d2 <= cs_d1;
      mem_prog <= 1'b0;
      mem_erase <= 1'b0;

      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          if (pend_er) mem_erase <= 1'b1;
          else         mem_prog  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end

      if (cs_d1) begin
        bcnt <= '0; cyc <= '0; ocnt <= '0;
        mode <= M_IGN; armed <= 1'b0; dphase <= 1'b0;
        if (cs_up && armed && wp_n && hw_rst_n && !busy) begin
          busy    <= 1'b1;
          pend_er <= (mode == M_ER);
          cnt     <= (mode == M_ER) ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
        end
      end else begin
        if (rise && !dphase) begin
          sh   <= shn;
          bcnt <= bcnt + 1'b1;
          if (bcnt == 3'd7) begin
            if (cyc != 3'd7) cyc <= cyc + 1'b1;
            case (cyc)
              3'd0: begin
                if (busy) begin
                  if (shn == 8'hFF) begin
                    busy <= 1'b0; cnt <= '0;
                    mem_prog <= 1'b0; mem_erase <= 1'b0;
                    mode <= M_IGN;
                  end else if (shn == 8'h9F) begin
                    mode <= M_ST; dphase <= 1'b1;
                  end else begin
                    mode <= M_IGN;
                  end
                end else begin
                  case (shn)
                    8'hFF:   mode <= M_RD;
                    8'h10:   mode <= M_PG;
                    8'h20:   mode <= M_ER;
                    8'h9F:   begin mode <= M_ST; dphase <= 1'b1; end
                    default: mode <= M_IGN;
                  endcase
                end
              end
              3'd1: if (is_wr || mode == M_RD) a_hi[ADDR_W-9:8] <= shn[ADDR_W-17:0];
              3'd2: if (is_wr || mode == M_RD) a_hi[7:0] <= shn;
              3'd3: begin
                if (mode == M_ER)      addr <= {addr_full[ADDR_W-1:8], 8'h00};
                else if (mode != M_IGN && mode != M_ST) addr <= addr_full;
              end
              3'd4: begin
                if (mode == M_PG) begin
                  if (shn == 8'hFF) mode <= M_IGN;
                  else              wdata <= shn;
                end else if (mode == M_ER && shn != 8'hD0) begin
                  mode <= M_IGN;
                end
              end
              3'd5: begin
                if (mode == M_RD) dphase <= 1'b1;
                if (is_wr)        armed  <= 1'b1;
              end
              default: ;
            endcase
          end
        end

        if (fall && dphase) begin
          ocnt <= ocnt + 1'b1;
          if (ocnt == 3'd0) begin
            so_r <= nb[7];
            osh  <= {nb[6:0], 1'b0};
            if (mode == M_RD) addr <= addr + 1'b1;
          end else begin
            so_r <= osh[7];
            osh  <= {osh[6:0], 1'b0};
          end
        end
      end
    end
  end

  a_r6_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_d1 |=> !so_en);
  a_r12_exclusive_requests: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_prog && mem_erase));
  a_r12_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_prog || mem_erase) |=> !(mem_prog || mem_erase));
  a_r3_commit_at_interval_end: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_prog || mem_erase) |-> ($past(busy) && !busy));
  a_r9_start_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wp_n && hw_rst_n));
  a_r10_no_start_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_d1));

endmodule

// File: tb/sflash_front_test.sv
`timescale 1ns/100ps
module sflash_front_test;
  localparam int PCYC = 1500;
  localparam int ECYC = 3000;
  localparam int HALF = 30;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic wp_n = 1'b1, hw_rst_n = 1'b1;
  logic so, so_en, mem_prog, mem_erase;
  logic [16:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 8'hFF;

  always #2.5 clk = ~clk;

  sflash_front #(.ADDR_W(17), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .wp_n(wp_n), .hw_rst_n(hw_rst_n), .so(so), .so_en(so_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_prog(mem_prog),
    .mem_erase(mem_erase), .mem_rdata(mem_rdata));

  typedef struct packed { logic er; logic [16:0] a; logic [7:0] d; } op_t;
  op_t expq[$];
  op_t got;
  logic [7:0] mem [int];
  int n_chk = 0, n_fail = 0;
  logic prev_pulse = 1'b0;

  function automatic logic [7:0] model_rd(input logic [16:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) mem_rdata <= model_rd(mem_addr);

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pulse) chk("R12 request lasts one cycle", {30'b0, mem_prog, mem_erase}, 32'd0);
      if (mem_prog || mem_erase) begin
        chk("R12 requests exclusive", {31'b0, mem_prog && mem_erase}, 32'd0);
        if (expq.size() == 0) begin
          chk("R7 R8 R9 R10 R11 unexpected array request", 32'd1, 32'd0);
        end else begin
          got = expq.pop_front();
          chk("R3 R4 request kind", {31'b0, mem_erase}, {31'b0, got.er});
          chk("R3 R4 request address", {15'b0, mem_addr}, {15'b0, got.a});
          if (!got.er) begin
            chk("R3 program data", {24'b0, mem_wdata}, {24'b0, got.d});
            mem[int'(got.a)] = got.d;
          end else begin
            for (int i = 0; i < 256; i++) mem[int'({got.a[16:8], 8'h00}) + i] = 8'hFF;
          end
        end
      end
      prev_pulse <= mem_prog || mem_erase;
    end
  end

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic en);
    en = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      #HALF;
      rx[i] = so;
      en = en | so_en;
      sck = 1'b1;
      #HALF;
      sck = 1'b0;
    end
  endtask

  task automatic sel();   cs_n = 1'b0; #HALF; endtask
  task automatic desel(); #HALF; cs_n = 1'b1; #(2*HALF); endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2.5;
  endtask

  task automatic do_write(input logic [7:0] op, input logic [23:0] a, input logic [7:0] b4,
                          input bit full, input bit exp_go, input bit er);
    logic [7:0] rx; logic en; logic any;
    any = 1'b0;
    sel();
    xbyte(op, rx, en);       any |= en;
    xbyte(a[23:16], rx, en); any |= en;
    xbyte(a[15:8], rx, en);  any |= en;
    xbyte(a[7:0], rx, en);   any |= en;
    xbyte(b4, rx, en);       any |= en;
    if (full) begin xbyte(8'h00, rx, en); any |= en; end
    chk("R6 no output during write command", {31'b0, any}, 32'd0);
    if (exp_go) expq.push_back(op_t'{er, er ? {a[16:8], 8'h00} : a[16:0], b4});
    desel();
  endtask

  task automatic do_read(input logic [23:0] a, input int n, input string tag);
    logic [7:0] rx; logic en; logic any; logic [16:0] aa;
    any = 1'b0;
    sel();
    xbyte(8'hFF, rx, en);    any |= en;
    xbyte(a[23:16], rx, en); any |= en;
    xbyte(a[15:8], rx, en);  any |= en;
    xbyte(a[7:0], rx, en);   any |= en;
    xbyte(8'h00, rx, en);    any |= en;
    xbyte(8'h00, rx, en);    any |= en;
    chk("R6 no output in read input phase", {31'b0, any}, 32'd0);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, rx, en);
      aa = a[16:0] + 17'(k);
      chk(tag, {24'b0, rx}, {24'b0, model_rd(aa)});
      chk("R6 output enabled in read data", {31'b0, en}, 32'd1);
    end
    desel();
    chk("R6 output released after deselect", {31'b0, so_en}, 32'd0);
  endtask

  task automatic do_status(input int n, input logic [7:0] exp, input string tag);
    logic [7:0] rx; logic en;
    sel();
    xbyte(8'h9F, rx, en);
    chk("R6 no output during status opcode", {31'b0, en}, 32'd0);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, rx, en);
      chk(tag, {24'b0, rx}, {24'b0, exp});
    end
    desel();
  endtask

  task automatic abort_cmd();
    logic [7:0] rx; logic en;
    sel();
    xbyte(8'hFF, rx, en);
    desel();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    #20 rst_n = 1'b1;
    #20;
    chk("R6 reset so_en", {31'b0, so_en}, 32'd0);
    chk("R12 reset mem_prog", {31'b0, mem_prog}, 32'd0);
    chk("R12 reset mem_erase", {31'b0, mem_erase}, 32'd0);

    do_status(2, 8'h01, "R5 idle status repeats");

    do_write(8'h10, 24'h000123, 8'hA5, 1, 1, 0);
    do_status(2, 8'h00, "R5 busy during program");
    wait_cyc(PCYC);
    do_status(1, 8'h01, "R5 ready after program");
    do_write(8'h10, 24'h000124, 8'h3C, 1, 1, 0); wait_cyc(PCYC);
    do_write(8'h10, 24'h01FFFF, 8'h77, 1, 1, 0); wait_cyc(PCYC);
    do_write(8'h10, 24'h000000, 8'h11, 1, 1, 0); wait_cyc(PCYC);

    do_read(24'h000123, 3, "R1 streaming read");
    do_read(24'hFE0123, 2, "R2 upper address bits ignored");
    do_read(24'h01FFFF, 2, "R2 wrap to address zero");

    do_write(8'h20, 24'h000155, 8'hD0, 1, 1, 1);
    do_status(1, 8'h00, "R4 busy during erase");
    wait_cyc(ECYC);
    do_read(24'h000123, 2, "R4 sector erased");
    do_read(24'h000000, 1, "R4 other sector kept");

    do_write(8'h10, 24'h000200, 8'hFF, 1, 0, 0);
    do_status(1, 8'h01, "R7 program cancelled");
    do_write(8'h20, 24'h000000, 8'hFF, 1, 0, 1);
    do_status(1, 8'h01, "R7 erase cancelled");
    do_write(8'h20, 24'h000000, 8'h00, 1, 0, 1);
    do_status(1, 8'h01, "R10 bad confirm ignored");

    do_write(8'h20, 24'h000000, 8'hD0, 1, 0, 1);
    do_status(1, 8'h00, "R8 busy before abort");
    abort_cmd();
    do_status(1, 8'h01, "R8 ready after abort");
    wait_cyc(ECYC);
    do_read(24'h000000, 1, "R8 memory unchanged");

    wp_n = 1'b0;
    do_write(8'h10, 24'h000300, 8'hAB, 1, 0, 0);
    wp_n = 1'b1;
    do_status(1, 8'h01, "R9 write protect blocks");
    hw_rst_n = 1'b0;
    do_write(8'h10, 24'h000301, 8'hCD, 1, 0, 0);
    hw_rst_n = 1'b1;
    do_status(1, 8'h01, "R9 reset pin blocks");
    wait_cyc(PCYC);
    do_read(24'h000300, 2, "R9 memory unchanged");

    do_write(8'h10, 24'h000400, 8'h12, 1, 1, 0);
    do_write(8'h10, 24'h000401, 8'h34, 1, 0, 0);
    do_status(1, 8'h00, "R10 still busy after ignored write");
    wait_cyc(2 * PCYC);
    do_read(24'h000400, 2, "R10 ignored write left no trace");

    do_write(8'h10, 24'h000500, 8'hAA, 0, 0, 0);
    do_status(1, 8'h01, "R11 early deselect discards");
    wait_cyc(PCYC);
    do_read(24'h000500, 1, "R11 memory unchanged");

    wait_cyc(100);
    chk("R3 R4 all expected requests seen", expq.size(), 32'd0);
    finish_run();
  end
endmodule